// File: doc/BRIEF.md
# Shared Interrupt Flag Aggregator

This block gathers peripheral event signals into latched flags and maps them onto seven processor interrupt request lines. Each flag is held in one byte-wide register on a small register bus. Software clears a flag by writing a byte in which that bit is zero and every other bit is one. A written one never changes a flag. A byte-wide read-modify-write therefore cannot lose a flag that the hardware sets between the read and the write.

Three of the request lines are shared. Line 2 is driven by two collision flags, line 4 by the rising-edge and falling-edge flags of the PLL lock level, and line 6 by the transfer-busy and one-second flags, each gated by its own enable bit. Every line is edge-triggered and holds its request until the processor acknowledges it. A shared line raises a new request only when the OR of its flags rises again. Lines 2 and 3 have a programmable edge polarity. The pin for line 5 is inverted before edge detection, so that line responds to a falling pin. Two more flags record button presses and wake-timer expiry; these flags drive no line.

All raw inputs pass through a synchronizer of SYNC_DEPTH flops before any edge detection.

Top module: `irq_flag_agg`

## Requirements
- R1: After reset, the flag register (address 0), the enable register (address 1) and the polarity register (address 2) all read 0x00, and every request output is low.
- R2: A rising edge on a source input sets its bit in the flag register: bit 0 transfer-busy, bit 1 one-second tick, bit 2 collision 1, bit 3 collision 0, bit 4 button, bit 5 wake timer. A rising edge of the PLL lock level sets bit 6 and a falling edge sets bit 7.
- R3: A write to address 0 clears each flag bit written as 0 and leaves each bit written as 1 unchanged. A written 1 never sets a flag.
- R4: If a flag is set by hardware in the same cycle that a write clears it, the flag ends up set.
- R5: The button flag sets again on each new press after software has cleared it.
- R6: Line 6 is the OR of (flag bit 0 AND enable bit 0) and (flag bit 1 AND enable bit 1) of address 1. With both enables at zero, line 6 never raises a request.
- R7: A shared line (2, 4, 6) raises a request only on a fresh rising edge of its OR. While the OR stays high, a further flag set raises nothing.
- R8: Line 2 is the OR of flag bits 2 and 3, with its edge chosen by bit 0 of address 2 (0 = rising, 1 = falling). Line 4 is the OR of flag bits 6 and 7 and fires on a rising edge.
- R9: The external pins `ext_pin_i[0]`, `[1]` and `[2]` drive lines 0, 1 and 3, and fire on a rising edge. Line 3 follows bit 1 of address 2 (1 = falling). `ext_pin_i[3]` drives line 5 and fires on a falling pin edge only.
- R10: A pending line clears when its acknowledge bit is high for one cycle. An acknowledge on an idle line has no effect. An edge that arrives in the same cycle as the acknowledge keeps the line pending.
- R11: With SYNC_DEPTH = 2, a pin level first sampled at clock edge k raises its request output after edge k+2. A line fed from flags raises its request one edge later than its flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address (0 flags, 1 enables, 2 polarity) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| src_xfer_i | input | 1 | Transfer-busy event level |
| src_tick_i | input | 1 | One-second tick event level |
| src_coll0_i | input | 1 | Collision 0 event level |
| src_coll1_i | input | 1 | Collision 1 event level |
| src_button_i | input | 1 | Push-button level |
| src_wake_i | input | 1 | Wake-timer timeout level |
| src_pll_lock_i | input | 1 | PLL lock level |
| ext_pin_i | input | 4 | External pins for lines 0, 1, 3, 5 |
| irq_ack_i | input | 7 | Per-line acknowledge |
| irq_req_o | output | 7 | Per-line interrupt request |

## Verification
The bench builds the block with SYNC_DEPTH = 2, the default. This depth fixes the latency from pin to request at two edges and from flag to shared line at three. With those latencies known, the bench can place a software clear, or an acknowledge, in exactly the cycle in which a hardware set or a line edge lands. It can then check that the set wins, and that an edge beats an acknowledge in the same cycle. The behavioural model is written in terms of SYNC_DEPTH, so it also follows other depths; the hard-coded timing checks assume the default.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int REG_AW    = 2;
    localparam int REG_DW    = 8;
    localparam int NUM_LINES = 7;
    localparam int NUM_EXT   = 4;
    localparam int NUM_LVL   = REG_DW - 1;      // six plain sources plus the PLL level
    localparam int RAW_W     = NUM_LVL + NUM_EXT;

    localparam logic [REG_AW-1:0] ADR_FLAG = 2'd0;
    localparam logic [REG_AW-1:0] ADR_ENA  = 2'd1;
    localparam logic [REG_AW-1:0] ADR_POL  = 2'd2;

    localparam int FB_XFER  = 0;
    localparam int FB_TICK  = 1;
    localparam int FB_COLL1 = 2;
    localparam int FB_COLL0 = 3;
    localparam int FB_BTN   = 4;
    localparam int FB_WAKE  = 5;
    localparam int FB_PLLR  = 6;
    localparam int FB_PLLF  = 7;

    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_PEND = 1'b1
    } line_state_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_PROG = 2'd2
    } edge_mode_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W     = 1,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[DEPTH-1];
endmodule

// File: rtl/irq_line.sv
module irq_line
    import irq_agg_pkg::*;
#(
    parameter edge_mode_e MODE = EDGE_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic pol_i,
    input  logic ack_i,
    output logic req_o
);
    logic        sig_prev;
    logic        use_fall;
    logic        fire;
    line_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_prev <= 1'b0;
        else        sig_prev <= sig_i;
    end

    assign use_fall = (MODE == EDGE_FALL) || ((MODE == EDGE_PROG) && pol_i);
    assign fire     = use_fall ? (~sig_i & sig_prev) : (sig_i & ~sig_prev);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LN_IDLE;
        else        st_q <= st_d;
    end

    // transitions: IDLE->PEND on edge; PEND->IDLE on ack unless an edge lands together
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LN_IDLE: if (fire)           st_d = LN_PEND;
            LN_PEND: if (ack_i && !fire) st_d = LN_IDLE;
        endcase
    end

    // output
    always_comb begin
        req_o = (st_q == LN_PEND);
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_LVL-1:0] lvl_i,
    input  logic              clr_we_i,
    input  logic [REG_DW-1:0] keep_mask_i,
    output logic [REG_DW-1:0] flag_o,
    output logic [REG_DW-1:0] set_o
);
    localparam int PLAIN = NUM_LVL - 1;

    logic [NUM_LVL-1:0] lvl_prev;
    logic [REG_DW-1:0]  flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_prev <= '0;
        else        lvl_prev <= lvl_i;
    end

    assign set_o[PLAIN-1:0] = lvl_i[PLAIN-1:0] & ~lvl_prev[PLAIN-1:0];
    assign set_o[FB_PLLR]   =  lvl_i[PLAIN] & ~lvl_prev[PLAIN];
    assign set_o[FB_PLLF]   = ~lvl_i[PLAIN] &  lvl_prev[PLAIN];

    // a zero in the mask clears, a hardware set always wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & (clr_we_i ? keep_mask_i : '1)) | set_o;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/irq_flag_agg.sv
module irq_flag_agg
    import irq_agg_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [REG_DW-1:0]    reg_wdata,
    output logic [REG_DW-1:0]    reg_rdata,
    input  logic                 src_xfer_i,
    input  logic                 src_tick_i,
    input  logic                 src_coll0_i,
    input  logic                 src_coll1_i,
    input  logic                 src_button_i,
    input  logic                 src_wake_i,
    input  logic                 src_pll_lock_i,
    input  logic [NUM_EXT-1:0]   ext_pin_i,
    input  logic [NUM_LINES-1:0] irq_ack_i,
    output logic [NUM_LINES-1:0] irq_req_o
);
    logic [RAW_W-1:0]     raw;
    logic [RAW_W-1:0]     sync_q;
    logic [NUM_EXT-1:0]   ext_q;
    logic [REG_DW-1:0]    flag_q;
    logic [REG_DW-1:0]    flag_set;
    logic [1:0]           ena_q;
    logic [1:0]           pol_q;
    logic [NUM_LINES-1:0] line_sig;
    logic [NUM_LINES-1:0] line_pol;

    // line 5 pin is inverted ahead of the synchronizer
    assign raw = {~ext_pin_i[3], ext_pin_i[2:0],
                  src_pll_lock_i, src_wake_i, src_button_i,
                  src_coll0_i, src_coll1_i, src_tick_i, src_xfer_i};

    irq_sync #(.W(RAW_W), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (sync_q)
    );

    assign ext_q = sync_q[RAW_W-1:NUM_LVL];

    irq_flag_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_i       (sync_q[NUM_LVL-1:0]),
        .clr_we_i    (reg_wr && (reg_addr == ADR_FLAG)),
        .keep_mask_i (reg_wdata),
        .flag_o      (flag_q),
        .set_o       (flag_set)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q <= '0;
            pol_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADR_ENA) ena_q <= reg_wdata[1:0];
            if (reg_addr == ADR_POL) pol_q <= reg_wdata[1:0];
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADR_FLAG: reg_rdata = flag_q;
            ADR_ENA:  reg_rdata = {{(REG_DW-2){1'b0}}, ena_q};
            ADR_POL:  reg_rdata = {{(REG_DW-2){1'b0}}, pol_q};
            default:  reg_rdata = '0;
        endcase
    end

    assign line_sig[0] = ext_q[0];
    assign line_sig[1] = ext_q[1];
    assign line_sig[2] = flag_q[FB_COLL1] | flag_q[FB_COLL0];
    assign line_sig[3] = ext_q[2];
    assign line_sig[4] = flag_q[FB_PLLR] | flag_q[FB_PLLF];
    assign line_sig[5] = ext_q[3];
    assign line_sig[6] = (flag_q[FB_XFER] & ena_q[0]) | (flag_q[FB_TICK] & ena_q[1]);

    assign line_pol = {3'b000, pol_q[1], pol_q[0], 2'b00};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam edge_mode_e LMODE = (g == 2 || g == 3) ? EDGE_PROG : EDGE_RISE;
        irq_line #(.MODE(LMODE)) u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .sig_i (line_sig[g]),
            .pol_i (line_pol[g]),
            .ack_i (irq_ack_i[g]),
            .req_o (irq_req_o[g])
        );
    end
endmodule

// File: rtl/irq_flag_agg_chk.sv
module irq_flag_agg_chk
    import irq_agg_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [REG_AW-1:0]    reg_addr,
    input logic [REG_DW-1:0]    reg_wdata,
    input logic [REG_DW-1:0]    flags,
    input logic [REG_DW-1:0]    flag_set,
    input logic [1:0]           ena,
    input logic [NUM_LINES-1:0] irq_req,
    input logic [NUM_LINES-1:0] irq_ack
);
    logic past_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    // R3: zero bits of a flag write are cleared unless hardware set them
    a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADR_FLAG) |=>
            ((flags & ~$past(reg_wdata) & ~$past(flag_set)) == '0));

    // R3: a flag only rises where hardware signalled a set
    a_r3_no_write_set: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> ((flags & ~$past(flags) & ~$past(flag_set)) == '0));

    // R4: every hardware set lands, whatever was written
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> ((flags & $past(flag_set)) == $past(flag_set)));

    // R10: a request drops only after an acknowledge
    a_r10_ack_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> (($past(irq_req) & ~$past(irq_ack) & ~irq_req) == '0));

    // R6: line 6 rises only when an enabled source flag was set
    a_r6_gated_source: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && irq_req[6] && !$past(irq_req[6])) |->
            $past(|(flags[1:0] & ena)));
endmodule

bind irq_flag_agg irq_flag_agg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .flags     (flag_q),
    .flag_set  (flag_set),
    .ena       (ena_q),
    .irq_req   (irq_req_o),
    .irq_ack   (irq_ack_i)
);

// File: tb/tb_irq_flag_agg.sv
`timescale 1ns/1ps
module tb_irq_flag_agg;
    localparam int SYNC_DEPTH = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       src_xfer = 0, src_tick = 0, src_coll0 = 0, src_coll1 = 0;
    logic       src_button = 0, src_wake = 0, src_pll = 0;
    logic [3:0] ext_pin = 4'b1000;
    logic [6:0] irq_ack = '0;
    logic [6:0] irq_req;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    irq_flag_agg #(.SYNC_DEPTH(SYNC_DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_xfer_i(src_xfer), .src_tick_i(src_tick), .src_coll0_i(src_coll0),
        .src_coll1_i(src_coll1), .src_button_i(src_button), .src_wake_i(src_wake),
        .src_pll_lock_i(src_pll), .ext_pin_i(ext_pin), .irq_ack_i(irq_ack),
        .irq_req_o(irq_req)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [10:0] m_pipe[$];
    logic [10:0] m_prev;
    logic [7:0]  m_flags;
    logic [1:0]  m_ena, m_pol;
    logic [6:0]  m_lprev, m_pend;

    always @(posedge clk) begin
        logic [10:0] raw, s;
        logic [7:0]  setv;
        logic [6:0]  lsig, fire;
        raw = {~ext_pin[3], ext_pin[2:0], src_pll, src_wake, src_button,
               src_coll0, src_coll1, src_tick, src_xfer};
        if (!rst_n) begin
            m_pipe = {};
            for (int i = 0; i < SYNC_DEPTH; i++) m_pipe.push_back('0);
            m_prev = '0; m_flags = '0; m_ena = '0; m_pol = '0;
            m_lprev = '0; m_pend = '0;
        end else begin
            s = m_pipe[SYNC_DEPTH-1];
            setv = {~s[6] & m_prev[6], s[6] & ~m_prev[6], s[5:0] & ~m_prev[5:0]};
            lsig = {(m_flags[0] & m_ena[0]) | (m_flags[1] & m_ena[1]), s[10],
                    m_flags[6] | m_flags[7], s[9], m_flags[2] | m_flags[3], s[8], s[7]};
            for (int i = 0; i < 7; i++) begin
                if ((i == 2 && m_pol[0]) || (i == 3 && m_pol[1]))
                    fire[i] = ~lsig[i] & m_lprev[i];
                else
                    fire[i] = lsig[i] & ~m_lprev[i];
            end
            m_pend  = fire | (m_pend & ~irq_ack);
            m_lprev = lsig;
            if (reg_wr && reg_addr == 2'd0) m_flags = m_flags & reg_wdata;
            m_flags = m_flags | setv;
            if (reg_wr && reg_addr == 2'd1) m_ena = reg_wdata[1:0];
            if (reg_wr && reg_addr == 2'd2) m_pol = reg_wdata[1:0];
            m_prev = s;
            m_pipe.push_front(raw);
            void'(m_pipe.pop_back());
        end
    end

    always @(negedge clk) begin
        logic [7:0] exp_rd;
        if (rst_n) begin
            case (reg_addr)
                2'd0:    exp_rd = m_flags;
                2'd1:    exp_rd = {6'd0, m_ena};
                2'd2:    exp_rd = {6'd0, m_pol};
                default: exp_rd = 8'd0;
            endcase
            chk("R11 model irq_req", {1'b0, irq_req}, {1'b0, m_pend});
            chk("R3 model reg_rdata", reg_rdata, exp_rd);
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic ack(input int i);
        irq_ack[i] = 1'b1;
        step(1);
        irq_ack = '0;
    endtask

    task automatic req_chk(input int i, input logic exp, input string tag);
        chk(tag, {7'd0, irq_req[i]}, {7'd0, exp});
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(3);
        rd_chk(0, 8'h00, "R1 flags after reset");
        rd_chk(1, 8'h00, "R1 enables after reset");
        rd_chk(2, 8'h00, "R1 polarity after reset");
        chk("R1 requests after reset", {1'b0, irq_req}, 8'h00);

        src_xfer = 1; step(4);
        rd_chk(0, 8'h01, "R2 transfer-busy bit0");
        req_chk(6, 1'b0, "R6 line6 idle with enables off");
        wr_reg(0, 8'hFF); step(1);
        rd_chk(0, 8'h01, "R3 written ones keep flags");
        wr_reg(1, 8'h01); step(3);
        req_chk(6, 1'b1, "R6 line6 after enable");
        rd_chk(1, 8'h01, "R6 enable readback");
        ack(6); step(1);
        req_chk(6, 1'b0, "R10 ack clears line6");

        src_xfer = 0;
        wr_reg(1, 8'h03);
        src_tick = 1; step(5);
        rd_chk(0, 8'h03, "R2 tick bit1");
        req_chk(6, 1'b0, "R7 no request while OR held");
        wr_reg(0, 8'hFE); step(1);
        rd_chk(0, 8'h02, "R3 zero clears bit0 only");
        wr_reg(0, 8'hFD); step(1);
        rd_chk(0, 8'h00, "R3 zero clears bit1");
        src_xfer = 1; step(5);
        req_chk(6, 1'b1, "R7 fresh rise of OR");
        ack(6);

        // set and clear land on the same edge
        src_button = 1; step(2);
        reg_addr = 0; reg_wdata = 8'h00; reg_wr = 1'b1;
        step(1);
        reg_wr = 1'b0;
        rd_chk(0, 8'h10, "R4 hardware set beats clear");

        src_button = 0; step(3);
        wr_reg(0, 8'hEF); step(1);
        rd_chk(0, 8'h00, "R3 button flag cleared");
        src_button = 1; step(4);
        rd_chk(0, 8'h10, "R5 second press sets again");
        wr_reg(0, 8'h00); src_button = 0;

        src_wake = 1; step(4);
        rd_chk(0, 8'h20, "R2 wake bit5");
        wr_reg(0, 8'h00);

        src_coll0 = 1; step(5);
        rd_chk(0, 8'h08, "R2 collision0 bit3");
        req_chk(2, 1'b1, "R8 line2 rising");
        ack(2);
        src_coll1 = 1; step(4);
        rd_chk(0, 8'h0C, "R2 collision1 bit2");
        req_chk(2, 1'b0, "R7 line2 held high");
        wr_reg(2, 8'h01); step(1);
        wr_reg(0, 8'hF3); step(3);
        req_chk(2, 1'b1, "R8 line2 falling polarity");
        rd_chk(0, 8'h00, "R3 collision flags cleared");
        ack(2);
        rd_chk(2, 8'h01, "R8 polarity readback");

        src_pll = 1; step(5);
        rd_chk(0, 8'h40, "R2 pll rise bit6");
        req_chk(4, 1'b1, "R8 line4 rising");
        ack(4);
        src_pll = 0; step(5);
        rd_chk(0, 8'hC0, "R2 pll fall bit7");
        req_chk(4, 1'b0, "R7 line4 held high");
        wr_reg(0, 8'h00);

        ext_pin[1] = 1; step(2);
        req_chk(1, 1'b0, "R11 line1 before latency");
        step(1);
        req_chk(1, 1'b1, "R11 line1 after two edges");
        ack(1);
        ext_pin[1] = 0; step(5);
        req_chk(1, 1'b0, "R9 line1 ignores falling pin");

        ext_pin[0] = 1; step(4);
        req_chk(0, 1'b1, "R9 line0 rising");
        ext_pin[0] = 0; step(5);
        ext_pin[0] = 1; step(2);
        irq_ack[0] = 1'b1; step(1);
        irq_ack = '0;
        req_chk(0, 1'b1, "R10 edge beats same-cycle ack");
        ack(0); step(1);
        req_chk(0, 1'b0, "R10 ack clears line0");
        ack(0); step(1);
        req_chk(0, 1'b0, "R10 ack on idle line");

        ext_pin[2] = 1; step(4);
        req_chk(3, 1'b1, "R9 line3 rising");
        ack(3);
        wr_reg(2, 8'h02);
        ext_pin[2] = 0; step(4);
        req_chk(3, 1'b1, "R9 line3 falling polarity");
        ack(3);

        ext_pin[3] = 0; step(4);
        req_chk(5, 1'b1, "R9 line5 falling pin");
        ack(5);
        ext_pin[3] = 1; step(5);
        req_chk(5, 1'b0, "R9 line5 ignores rising pin");

        step(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule